// File: doc/BRIEF.md
# Round-Robin Group Dispatcher

This block fans a single stream of 128-bit words out to four identical processing engines and merges their results back into one stream. A job starts with a pulse that carries the total number of words. The dispatcher cuts the incoming words into groups of `GROUP` words. The final group may be shorter. Group 0 goes to engine 0, group 1 to engine 1, and so on, wrapping around after the last engine.

Each engine works on at most one group at a time. An engine stays reserved from the first word of a group sent to it until the last result word of that group has been taken back out. When the next engine in the rotation is still reserved, the dispatcher waits for it instead of moving on to another engine. The collector visits the engines in the same rotation. Result groups therefore leave in input order, even when a later engine finishes earlier.

Every engine shares the block's single clock. When the last output word of a job is accepted downstream, the block raises a one-cycle done pulse and returns to idle.

Top module: `rr_group_dispatch`

## Requirements
- R1: A `start` pulse while idle with a nonzero `job_words` begins a job of that many words. A `start` pulse during a job is ignored, and the running job completes with its original word count and a single done pulse.
- R2: Input words are cut into consecutive groups of `GROUP` words. Group k of a job goes to engine k mod `NENG`, and every job begins at engine 0.
- R3: `eng_req_last` is 1 on the final word of each group. When `job_words` is not a multiple of `GROUP`, the last group holds only the remaining words.
- R4: An engine receives no word of a new group until every result word of its previous group has been accepted at the output. The dispatcher stalls on that engine and never skips it.
- R5: Output words appear in input order. Each output word is the response of the engine that handled its group. `out_last` is 1 on the final word of each group.
- R6: `job_done` is a one-cycle pulse in the cycle after the final output word of a job is accepted. A `start` with `job_words` equal to 0 gives the pulse in the next cycle with no stream traffic.
- R7: While idle, `in_ready`, `out_valid` and every `eng_req_valid` and `eng_rsp_ready` bit are 0, so words offered at the input are left untouched.
- R8: After reset the block is idle and `job_done` is 0.
- R9: At most one engine sees a valid request, and at most one engine sees a response ready, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the engines |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse |
| job_words | input | CW | Word count of the job, sampled with `start` |
| job_done | output | 1 | One-cycle pulse when the job has fully drained |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | DW | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | DW | Output word |
| out_last | output | 1 | Final word of a result group |
| eng_req_valid | output | NENG | Per-engine request valid |
| eng_req_ready | input | NENG | Per-engine request ready |
| eng_req_data | output | NENG*DW | Per-engine request word, engine i in slice i |
| eng_req_last | output | NENG | Final word of a group, per engine |
| eng_rsp_valid | input | NENG | Per-engine response valid |
| eng_rsp_ready | output | NENG | Per-engine response ready |
| eng_rsp_data | input | NENG*DW | Per-engine response word, engine i in slice i |

## Verification
The embedded assertions check the following on every cycle:
- only one engine request and one engine response handshake can be active;
- the block is quiet while idle;
- the done pulse lasts a single cycle and has a legitimate cause;
- the collector never runs ahead of the dispatcher.

Some properties depend on whole job histories, and only the bench scenarios can show them:
- correct group-to-engine mapping;
- shortened final groups;
- restoration of order when engines finish out of order;
- the stall on a reserved engine, which is caught by engine models that claim readiness even while busy;
- ignored mid-job starts.

// File: rtl/rr_group_dispatch.sv
module rr_group_dispatch #(
  parameter int DW    = 128,
  parameter int NENG  = 4,
  parameter int GROUP = 4,
  parameter int CW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    job_words,
  output logic             job_done,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic [NENG-1:0]  eng_req_valid,
  input  logic [NENG-1:0]  eng_req_ready,
  output logic [NENG*DW-1:0] eng_req_data,
  output logic [NENG-1:0]  eng_req_last,
  input  logic [NENG-1:0]  eng_rsp_valid,
  output logic [NENG-1:0]  eng_rsp_ready,
  input  logic [NENG*DW-1:0] eng_rsp_data
);
  localparam int SW = (NENG > 1) ? $clog2(NENG) : 1;
  localparam int PW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [SW-1:0] SEL_MAX = SW'(NENG - 1);
  localparam logic [PW-1:0] POS_MAX = PW'(GROUP - 1);

  logic            active;
  logic [CW-1:0]   in_left, col_left;
  logic [SW-1:0]   dsel, csel;
  logic [PW-1:0]   dpos, cpos;
  logic [NENG-1:0] ebusy;

  wire can_disp = active && (in_left != '0) && ((dpos != '0) || !ebusy[dsel]);
  wire d_last   = (dpos == POS_MAX) || (in_left == CW'(1));
  wire can_col  = active && (col_left != '0) && ebusy[csel];

  assign in_ready  = can_disp && eng_req_ready[dsel];
  assign out_valid = can_col && eng_rsp_valid[csel];
  assign out_data  = eng_rsp_data[csel*DW +: DW];
  assign out_last  = (cpos == POS_MAX) || (col_left == CW'(1));

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  for (genvar i = 0; i < NENG; i++) begin : g_eng
    assign eng_req_valid[i]          = can_disp && in_valid && (dsel == SW'(i));
    assign eng_req_data[i*DW +: DW]  = in_data;
    assign eng_req_last[i]           = d_last;
    assign eng_rsp_ready[i]          = can_col && out_ready && (csel == SW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      in_left  <= '0;
      col_left <= '0;
      dsel     <= '0;
      csel     <= '0;
      dpos     <= '0;
      cpos     <= '0;
      ebusy    <= '0;
      job_done <= 1'b0;
    end else begin
      job_done <= (out_fire && col_left == CW'(1)) || (start && !active && job_words == '0);
      if (!active) begin
        if (start && job_words != '0) begin
          active   <= 1'b1;
          in_left  <= job_words;
          col_left <= job_words;
          dsel     <= '0;
          csel     <= '0;
          dpos     <= '0;
          cpos     <= '0;
        end
      end else begin
        if (in_fire) begin
          in_left <= in_left - CW'(1);
          dpos    <= d_last ? '0 : dpos + PW'(1);
          if (d_last) dsel <= (dsel == SEL_MAX) ? '0 : dsel + SW'(1);
        end
        if (out_fire) begin
          col_left <= col_left - CW'(1);
          cpos     <= out_last ? '0 : cpos + PW'(1);
          if (out_last) csel <= (csel == SEL_MAX) ? '0 : csel + SW'(1);
          if (col_left == CW'(1)) active <= 1'b0;
        end
      end
      for (int i = 0; i < NENG; i++) begin
        if (in_fire && dpos == '0 && dsel == SW'(i)) ebusy[i] <= 1'b1;
        else if (out_fire && out_last && csel == SW'(i)) ebusy[i] <= 1'b0;
      end
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_req_valid)); // R9
  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_rsp_ready)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!in_ready && !out_valid && eng_req_valid == '0)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> ($past(out_fire && col_left == CW'(1)) || $past(start && !active && job_words == '0))); // R6
  AST_COL_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (col_left >= in_left)); // R5
  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && dpos == '0) |-> !ebusy[dsel]); // R4
endmodule

// File: tb/rr_group_dispatch_tb.sv
module rr_group_dispatch_tb;
  localparam int DW = 128, NENG = 4, GROUP = 4, CW = 32, MAXW = 64;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic start = 0, jrst = 0;
  logic [CW-1:0] job_words = '0;
  logic job_done, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [DW-1:0] in_data, out_data;
  logic [NENG-1:0] eng_req_valid, eng_req_ready, eng_req_last, eng_rsp_valid, eng_rsp_ready;
  logic [NENG*DW-1:0] eng_req_data, eng_rsp_data;

  rr_group_dispatch #(.DW(DW), .NENG(NENG), .GROUP(GROUP), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .job_words(job_words), .job_done(job_done),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready), .eng_req_data(eng_req_data),
    .eng_req_last(eng_req_last), .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
    .eng_rsp_data(eng_rsp_data));

  function automatic logic [DW-1:0] pat(int e);
    return {4{32'(e) * 32'h11111111 + 32'h5A5A0000}};
  endfunction

  logic [DW-1:0] src [MAXW];
  int job_n = 0, src_n = 0;
  int checks = 0, fails = 0;
  int s_checks = 0, s_fails = 0, e_checks = 0, e_fails = 0;

  int src_idx = 0;
  logic src_gate = 0;
  assign in_valid = (src_idx < src_n) && src_gate;
  assign in_data  = src[src_idx < MAXW ? src_idx : 0];
  always @(posedge clk) begin
    src_gate <= ($urandom % 4) != 0;
    if (jrst) src_idx <= 0;
    else if (in_valid && in_ready) src_idx <= src_idx + 1;
  end

  int rcv_idx = 0, done_cnt = 0;
  logic snk_gate = 0;
  assign out_ready = snk_gate;
  always @(posedge clk) begin
    snk_gate <= ($urandom % 3) != 0;
    if (jrst) begin rcv_idx <= 0; done_cnt <= 0; end
    else begin
      if (job_done) done_cnt <= done_cnt + 1;
      if (out_valid && out_ready) begin
        logic [DW-1:0] exp_d;
        logic exp_l;
        exp_d = src[rcv_idx % MAXW] ^ pat((rcv_idx / GROUP) % NENG);
        exp_l = (rcv_idx % GROUP == GROUP - 1) || (rcv_idx == job_n - 1);
        s_checks <= s_checks + 1;
        if (rcv_idx >= job_n || out_data !== exp_d || out_last !== exp_l) begin
          s_fails <= s_fails + 1;
          $display("FAIL R5 word %0d: data %h last %b, expected %h last %b", rcv_idx, out_data, out_last, exp_d, exp_l);
        end
        rcv_idx <= rcv_idx + 1;
      end
    end
  end

  logic [1:0] stg [NENG];
  int cnt [NENG], len [NENG], rd [NENG], dly [NENG];
  logic [DW-1:0] mem [NENG][GROUP];
  logic [NENG-1:0] rq_gate;
  int grp_seen = 0;
  assign eng_req_ready = rq_gate;
  for (genvar e = 0; e < NENG; e++) begin : g_model
    assign eng_rsp_valid[e] = (stg[e] == 2'd2);
    assign eng_rsp_data[e*DW +: DW] = mem[e][rd[e] % GROUP] ^ pat(e);
  end

  always @(posedge clk) begin
    for (int e = 0; e < NENG; e++) rq_gate[e] <= ($urandom % 4) != 0;
    if (!rst_n) begin
      for (int e = 0; e < NENG; e++) begin stg[e] <= 0; cnt[e] <= 0; len[e] <= 0; rd[e] <= 0; dly[e] <= 0; end
    end else begin
      if (jrst) grp_seen <= 0;
      for (int e = 0; e < NENG; e++) begin
        if (eng_req_valid[e] && eng_req_ready[e]) begin
          int w;
          logic exp_l;
          w = src_idx;
          exp_l = (w % GROUP == GROUP - 1) || (w == job_n - 1);
          e_checks <= e_checks + 1;
          if (stg[e] != 0) begin
            e_fails <= e_fails + 1;
            $display("FAIL R4 engine %0d got word %0d while holding a group, expected stall", e, w);
          end else if ((w / GROUP) % NENG != e || eng_req_last[e] !== exp_l || cnt[e] != w % GROUP) begin
            e_fails <= e_fails + 1;
            $display("FAIL R2/R3 word %0d: engine %0d last %b, expected engine %0d last %b", w, e, eng_req_last[e], (w / GROUP) % NENG, exp_l);
          end
          mem[e][cnt[e] % GROUP] <= eng_req_data[e*DW +: DW];
          if (eng_req_last[e]) begin
            stg[e] <= 1; len[e] <= cnt[e] + 1; cnt[e] <= 0;
            dly[e] <= (e == 0) ? 20 + $urandom % 20 : $urandom % 8;
          end else cnt[e] <= cnt[e] + 1;
        end
        if (stg[e] == 1) begin
          if (dly[e] == 0) begin stg[e] <= 2; rd[e] <= 0; end
          else dly[e] <= dly[e] - 1;
        end
        if (stg[e] == 2 && eng_rsp_ready[e]) begin
          if (rd[e] == len[e] - 1) stg[e] <= 0;
          rd[e] <= rd[e] + 1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic run_job(int n, int extra, bit mid_start);
    int t;
    @(negedge clk);
    for (int i = 0; i < MAXW; i++) src[i] = {$urandom, $urandom, $urandom, $urandom};
    job_n = n; src_n = n + extra; job_words = CW'(n); start = 1; jrst = 1;
    @(negedge clk);
    start = 0; jrst = 0;
    if (mid_start) begin
      repeat (6) @(negedge clk);
      job_words = 3; start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    check(t < 5000, "R6 job finished before watchdog", t, 5000);
    repeat (8) @(negedge clk);
    check(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
    check(rcv_idx == n, mid_start ? "R1 ignored start keeps word count" : "R5 output word count", rcv_idx, n);
    check(in_ready == 0 && out_valid == 0 && eng_req_valid == 0 && eng_rsp_ready == 0,
          "R7 idle quiet", int'(in_ready) + int'(out_valid), 0);
    check(src_idx == n, "R7 extra input words untouched", src_idx, n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(job_done == 0 && in_ready == 0 && out_valid == 0, "R8 reset state", int'(job_done), 0);
    rst_n = 1;
    @(negedge clk);
    check(job_done == 0 && eng_req_valid == 0 && eng_rsp_ready == 0, "R8 idle after reset", int'(job_done), 0);
    run_job(1, 0, 0);
    run_job(GROUP, 0, 0);
    run_job(GROUP + 1, 0, 0);
    run_job(GROUP * NENG, 0, 0);
    run_job(GROUP * NENG * 2 + 3, 0, 0);
    run_job(0, 0, 0);
    run_job(10, 3, 0);
    run_job(30, 0, 1);
    for (int k = 0; k < 6; k++) run_job(1 + $urandom % 40, 0, 0);
    checks += s_checks + e_checks;
    fails  += s_fails + e_fails;
    if (e_checks == 0) begin checks++; fails++; $display("FAIL R2 no engine traffic seen: actual 0 expected >0"); end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog expired: actual hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule